// File: doc/BRIEF.md
# Early Load Retirement Checkpoint Controller

This controller sits beside the retirement stage of an out-of-order core. When the instruction at the reorder-buffer head is a load still waiting on a long-latency miss, it does not let retirement stall. It commands the register file to snapshot the architectural state into one of four checkpoint slots, hands consumers a value taken from a small last-value predictor, and retires the load at once. While any checkpoint is live, the core runs in a speculative clear mode.

Every memory response carries the load tag, and the tag is compared against all live checkpoints. When the returned data matches the stored prediction, the checkpoint is freed once it is the oldest one. When it differs, the controller orders a rollback to that checkpoint and drops it together with every younger checkpoint. The predictor table learns from every response, including those for loads that never took a checkpoint.

Top module: `early_retire_ctrl`

## Requirements
- R1: `earlyRetire`, `snapTake` and `predValid` are high in a cycle exactly when `headValid`, `headLoadPending` and `headLongLat` are all high and fewer than four checkpoints are live.
- R2: Checkpoints are taken in age order. The slot on `snapSlot` is the oldest live slot plus the number of live slots, modulo 4, so the first slot taken after reset is 0.
- R3: `predValue` is the 16-entry table entry selected by `headPcLow`. Every entry is 0 after reset. On every `memRespValid`, the entry at `memRespIdx` is written with `memRespData`, and the new value is visible from the next cycle.
- R4: When four checkpoints are live and the trigger condition holds, `stallRetire` is 1 and `earlyRetire` is 0.
- R5: A response whose tag matches a live, unverified slot k and whose data differs from k's prediction raises `rollbackReq` with `rollbackSlot`=k in the next cycle. Slot k and every younger slot are freed. A freed slot's tag no longer matches.
- R6: When the oldest live slot has been verified correct, `ckptFree` is high in the following cycle with `ckptFreeSlot` naming it.
- R7: A younger slot verified correct is not freed while an older slot is live. Verified slots drain one per cycle, oldest first.
- R8: `clearMode` is 1 exactly when at least one checkpoint is live, and it returns to 0 after the last one is freed or rolled back.
- R9: If a mismatching response and a trigger share a cycle, the load still retires early with the table's old value, but its checkpoint is discarded by the rollback. The next snapshot then reuses the rolled-back slot.
- R10: A response whose tag matches no live slot raises neither `rollbackReq` nor `ckptFree`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| headValid | input | 1 | Reorder-buffer head holds an instruction |
| headLoadPending | input | 1 | Head is a load whose data has not arrived |
| headLongLat | input | 1 | Head load is marked long-latency |
| headTag | input | 6 | Tag of the head load |
| headPcLow | input | 4 | Low PC bits of the head load (predictor index) |
| earlyRetire | output | 1 | Retire the head load now |
| predValid | output | 1 | Predicted value is valid for consumers |
| predValue | output | 32 | Predicted load value |
| snapTake | output | 1 | Register file snapshot command |
| snapSlot | output | 2 | Checkpoint slot for the snapshot |
| stallRetire | output | 1 | Hold the head load, all slots busy |
| memRespValid | input | 1 | Memory response valid |
| memRespTag | input | 6 | Tag of the returning load |
| memRespData | input | 32 | Returned load data |
| memRespIdx | input | 4 | Predictor index of the returning load |
| rollbackReq | output | 1 | Restore the registers from a checkpoint |
| rollbackSlot | output | 2 | Checkpoint slot to restore |
| ckptFree | output | 1 | Checkpoint slot released |
| ckptFreeSlot | output | 2 | Released checkpoint slot |
| clearMode | output | 1 | Speculative mode active |

## Verification
The sharp collision is a new trigger and a mismatching response in the same cycle. Allocation and rollback then both want the pool pointers. The bench drives a trigger while a response with wrong data returns for the oldest slot. It then checks three things: the early retirement still used the table's old entry, the rollback names the oldest slot a cycle later with clear mode dropping to 0, and the next snapshot reuses that slot rather than the one handed out during the collision. A second overlap, a release and a rollback of a younger slot in flight together, is covered when a middle slot mispredicts and the oldest slot is then verified and freed.

// File: rtl/early_retire_pkg.sv
`timescale 1ns/1ps
package early_retire_pkg;
  parameter int CKPT_N    = 4;
  parameter int TAG_W     = 6;
  parameter int DATA_W    = 32;
  parameter int LVT_IDX_W = 4;
  localparam int SLOT_W   = $clog2(CKPT_N);
  localparam int CNT_W    = $clog2(CKPT_N + 1);
  localparam int LVT_N    = 1 << LVT_IDX_W;

  typedef struct packed {
    logic              alloc;
    logic [SLOT_W-1:0] allocSlot;
  } dpStrobe_t;
endpackage

// File: rtl/early_retire_dp.sv
`timescale 1ns/1ps
module early_retire_dp
  import early_retire_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [TAG_W-1:0]     headTag,
  input  logic [LVT_IDX_W-1:0] headPcLow,
  input  logic                 memRespValid,
  input  logic [TAG_W-1:0]     memRespTag,
  input  logic [DATA_W-1:0]    memRespData,
  input  logic [LVT_IDX_W-1:0] memRespIdx,
  output logic [DATA_W-1:0]    predValue,
  output logic [CKPT_N-1:0]    hitVec,
  output logic [CKPT_N-1:0]    eqVec
);
  logic [DATA_W-1:0] lvtQ  [LVT_N];
  logic [TAG_W-1:0]  tagQ  [CKPT_N];
  logic [DATA_W-1:0] predQ [CKPT_N];

  // last-value table: reset to zero, learns from every response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LVT_N; i++) lvtQ[i] <= '0;
    end else if (memRespValid) begin
      lvtQ[memRespIdx] <= memRespData;
    end
  end

  assign predValue = lvtQ[headPcLow];

  // per-slot tag and prediction storage with parallel compare
  for (genvar s = 0; s < CKPT_N; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.alloc && strobe.allocSlot == SLOT_W'(s)) begin
        tagQ[s]  <= headTag;
        predQ[s] <= predValue;
      end
    end
    assign hitVec[s] = memRespValid && (tagQ[s] == memRespTag);
    assign eqVec[s]  = (predQ[s] == memRespData);
  end
endmodule

// File: rtl/early_retire_ctl.sv
`timescale 1ns/1ps
module early_retire_ctl
  import early_retire_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              headValid,
  input  logic              headLoadPending,
  input  logic              headLongLat,
  input  logic [CKPT_N-1:0] hitVec,
  input  logic [CKPT_N-1:0] eqVec,
  output dpStrobe_t         strobe,
  output logic              earlyRetire,
  output logic              stallRetire,
  output logic [SLOT_W-1:0] snapSlot,
  output logic              rollbackReq,
  output logic [SLOT_W-1:0] rollbackSlot,
  output logic              ckptFree,
  output logic [SLOT_W-1:0] ckptFreeSlot,
  output logic              clearMode
);
  logic [CKPT_N-1:0] validQ, verQ;
  logic [SLOT_W-1:0] headPtrQ;
  logic [CNT_W-1:0]  countQ;

  logic              trigger, full, misAny, headDone, alloc;
  logic [CKPT_N-1:0] live, good, mis, killVec;
  logic [SLOT_W-1:0] misSlot, misAge, allocSlot;

  always_comb begin
    trigger   = headValid && headLoadPending && headLongLat;
    full      = (countQ == CNT_W'(CKPT_N));
    live      = validQ & ~verQ;
    good      = hitVec & live & eqVec;
    mis       = hitVec & live & ~eqVec;
    misAny    = |mis;
    misSlot   = '0;
    for (int i = 0; i < CKPT_N; i++) begin
      if (mis[i]) misSlot = SLOT_W'(i);
    end
    misAge    = misSlot - headPtrQ;
    for (int i = 0; i < CKPT_N; i++) begin
      killVec[i] = misAny && ((SLOT_W'(i) - headPtrQ) >= misAge);
    end
    headDone  = validQ[headPtrQ] && (verQ[headPtrQ] || good[headPtrQ]);
    allocSlot = headPtrQ + countQ[SLOT_W-1:0];
    alloc     = trigger && !full && !misAny;
  end

  assign earlyRetire      = trigger && !full;
  assign stallRetire      = trigger && full;
  assign snapSlot         = allocSlot;
  assign strobe.alloc     = alloc;
  assign strobe.allocSlot = allocSlot;
  assign clearMode        = (countQ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ       <= '0;
      verQ         <= '0;
      headPtrQ     <= '0;
      countQ       <= '0;
      rollbackReq  <= 1'b0;
      rollbackSlot <= '0;
      ckptFree     <= 1'b0;
      ckptFreeSlot <= '0;
    end else begin
      for (int i = 0; i < CKPT_N; i++) begin
        if (good[i]) verQ[i] <= 1'b1;
        if (killVec[i] || (headDone && headPtrQ == SLOT_W'(i))) begin
          validQ[i] <= 1'b0;
          verQ[i]   <= 1'b0;
        end
        if (alloc && allocSlot == SLOT_W'(i)) begin
          validQ[i] <= 1'b1;
          verQ[i]   <= 1'b0;
        end
      end
      if (misAny)
        countQ <= CNT_W'(misAge) - CNT_W'(headDone);
      else
        countQ <= countQ + CNT_W'(alloc) - CNT_W'(headDone);
      headPtrQ     <= headPtrQ + SLOT_W'(headDone);
      rollbackReq  <= misAny;
      rollbackSlot <= misSlot;
      ckptFree     <= headDone;
      ckptFreeSlot <= headPtrQ;
    end
  end
endmodule

// File: rtl/early_retire_ctrl.sv
`timescale 1ns/1ps
module early_retire_ctrl
  import early_retire_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 headValid,
  input  logic                 headLoadPending,
  input  logic                 headLongLat,
  input  logic [TAG_W-1:0]     headTag,
  input  logic [LVT_IDX_W-1:0] headPcLow,
  output logic                 earlyRetire,
  output logic                 predValid,
  output logic [DATA_W-1:0]    predValue,
  output logic                 snapTake,
  output logic [SLOT_W-1:0]    snapSlot,
  output logic                 stallRetire,
  input  logic                 memRespValid,
  input  logic [TAG_W-1:0]     memRespTag,
  input  logic [DATA_W-1:0]    memRespData,
  input  logic [LVT_IDX_W-1:0] memRespIdx,
  output logic                 rollbackReq,
  output logic [SLOT_W-1:0]    rollbackSlot,
  output logic                 ckptFree,
  output logic [SLOT_W-1:0]    ckptFreeSlot,
  output logic                 clearMode
);
  dpStrobe_t         strobe;
  logic [CKPT_N-1:0] hitVec, eqVec;
  logic              retireNow;

  early_retire_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .headValid(headValid), .headLoadPending(headLoadPending), .headLongLat(headLongLat),
    .hitVec(hitVec), .eqVec(eqVec), .strobe(strobe),
    .earlyRetire(retireNow), .stallRetire(stallRetire), .snapSlot(snapSlot),
    .rollbackReq(rollbackReq), .rollbackSlot(rollbackSlot),
    .ckptFree(ckptFree), .ckptFreeSlot(ckptFreeSlot), .clearMode(clearMode)
  );

  early_retire_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .headTag(headTag), .headPcLow(headPcLow),
    .memRespValid(memRespValid), .memRespTag(memRespTag),
    .memRespData(memRespData), .memRespIdx(memRespIdx),
    .predValue(predValue), .hitVec(hitVec), .eqVec(eqVec)
  );

  assign earlyRetire = retireNow;
  assign snapTake    = retireNow;
  assign predValid   = retireNow;
endmodule

// File: rtl/early_retire_chk.sv
`timescale 1ns/1ps
module early_retire_chk (
  input logic clk,
  input logic rstN,
  input logic headValid,
  input logic headLoadPending,
  input logic headLongLat,
  input logic earlyRetire,
  input logic stallRetire,
  input logic memRespValid,
  input logic rollbackReq,
  input logic ckptFree,
  input logic clearMode
);
  assert_trigger_qual_R1: assert property (@(posedge clk) disable iff (!rstN)
    earlyRetire |-> (headValid && headLoadPending && headLongLat));

  assert_full_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(earlyRetire && stallRetire));

  assert_stall_in_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    stallRetire |-> clearMode);

  assert_rollback_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    rollbackReq |-> $past(memRespValid));

  assert_free_in_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ckptFree |-> $past(clearMode));

  assert_alloc_enters_R2: assert property (@(posedge clk) disable iff (!rstN)
    (earlyRetire && !memRespValid) |=> clearMode);
endmodule

bind early_retire_ctrl early_retire_chk u_chk (
  .clk(clk), .rstN(rstN),
  .headValid(headValid), .headLoadPending(headLoadPending), .headLongLat(headLongLat),
  .earlyRetire(earlyRetire), .stallRetire(stallRetire),
  .memRespValid(memRespValid), .rollbackReq(rollbackReq),
  .ckptFree(ckptFree), .clearMode(clearMode)
);

// File: tb/early_retire_ctrl_tb.sv
`timescale 1ns/1ps
module early_retire_ctrl_tb;
  import early_retire_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic headValid = 0, headLoadPending = 0, headLongLat = 0;
  logic [TAG_W-1:0] headTag = '0;
  logic [LVT_IDX_W-1:0] headPcLow = '0;
  logic earlyRetire, predValid, snapTake, stallRetire;
  logic [DATA_W-1:0] predValue;
  logic [SLOT_W-1:0] snapSlot, rollbackSlot, ckptFreeSlot;
  logic memRespValid = 0;
  logic [TAG_W-1:0] memRespTag = '0;
  logic [DATA_W-1:0] memRespData = '0;
  logic [LVT_IDX_W-1:0] memRespIdx = '0;
  logic rollbackReq, ckptFree, clearMode;

  int nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  early_retire_ctrl u_dut (.*);

  typedef struct packed {
    logic trig; logic [7:0] tag; logic [3:0] pc;
    logic rv; logic [7:0] rtag; logic [7:0] rdata; logic [3:0] ridx;
    logic eEarly; logic eStall; logic [1:0] eSnap; logic [7:0] ePred;
    logic eRb; logic [1:0] eRbs; logic eRel; logic [1:0] eRels; logic eClr;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{0,8'd0, 4'd0,0,8'd0, 8'h00,4'd0, 0,0,2'd0,8'h00, 0,2'd0,0,2'd0,0},
    '{0,8'd0, 4'd0,1,8'd9, 8'h11,4'd3, 0,0,2'd0,8'h00, 0,2'd0,0,2'd0,0},
    '{1,8'd1, 4'd3,0,8'd0, 8'h00,4'd0, 1,0,2'd0,8'h11, 0,2'd0,0,2'd0,0},
    '{1,8'd2, 4'd5,0,8'd0, 8'h00,4'd0, 1,0,2'd1,8'h00, 0,2'd0,0,2'd0,1},
    '{1,8'd3, 4'd3,0,8'd0, 8'h00,4'd0, 1,0,2'd2,8'h11, 0,2'd0,0,2'd0,1},
    '{1,8'd4, 4'd6,0,8'd0, 8'h00,4'd0, 1,0,2'd3,8'h00, 0,2'd0,0,2'd0,1},
    '{1,8'd5, 4'd0,0,8'd0, 8'h00,4'd0, 0,1,2'd0,8'h00, 0,2'd0,0,2'd0,1},
    '{1,8'd5, 4'd0,1,8'd2, 8'h00,4'd5, 0,1,2'd0,8'h00, 0,2'd0,0,2'd0,1},
    '{1,8'd5, 4'd0,1,8'd1, 8'h11,4'd3, 0,1,2'd0,8'h00, 0,2'd0,0,2'd0,1},
    '{0,8'd0, 4'd0,0,8'd0, 8'h00,4'd0, 0,0,2'd0,8'h00, 0,2'd0,1,2'd0,1},
    '{0,8'd0, 4'd0,0,8'd0, 8'h00,4'd0, 0,0,2'd0,8'h00, 0,2'd0,1,2'd1,1},
    '{1,8'd6, 4'd3,0,8'd0, 8'h00,4'd0, 1,0,2'd0,8'h11, 0,2'd0,0,2'd0,1},
    '{1,8'd7, 4'd3,1,8'd3, 8'h22,4'd3, 1,0,2'd1,8'h11, 0,2'd0,0,2'd0,1},
    '{1,8'd8, 4'd3,0,8'd0, 8'h00,4'd0, 1,0,2'd2,8'h22, 1,2'd2,0,2'd0,0},
    '{0,8'd0, 4'd0,1,8'd8, 8'h22,4'd3, 0,0,2'd0,8'h00, 0,2'd0,0,2'd0,1},
    '{0,8'd0, 4'd0,0,8'd0, 8'h00,4'd0, 0,0,2'd0,8'h00, 0,2'd0,1,2'd2,0},
    '{1,8'd10,4'd1,0,8'd0, 8'h00,4'd0, 1,0,2'd3,8'h00, 0,2'd0,0,2'd0,0},
    '{1,8'd11,4'd1,0,8'd0, 8'h00,4'd0, 1,0,2'd0,8'h00, 0,2'd0,0,2'd0,1},
    '{1,8'd12,4'd1,0,8'd0, 8'h00,4'd0, 1,0,2'd1,8'h00, 0,2'd0,0,2'd0,1},
    '{0,8'd0, 4'd0,1,8'd11,8'h05,4'd1, 0,0,2'd0,8'h00, 0,2'd0,0,2'd0,1},
    '{1,8'd13,4'd2,0,8'd0, 8'h00,4'd0, 1,0,2'd0,8'h00, 1,2'd0,0,2'd0,1},
    '{0,8'd0, 4'd0,1,8'd10,8'h00,4'd1, 0,0,2'd0,8'h00, 0,2'd0,0,2'd0,1},
    '{0,8'd0, 4'd0,0,8'd0, 8'h00,4'd0, 0,0,2'd0,8'h00, 0,2'd0,1,2'd3,1},
    '{0,8'd0, 4'd0,1,8'd12,8'h09,4'd7, 0,0,2'd0,8'h00, 0,2'd0,0,2'd0,1},
    '{0,8'd0, 4'd0,1,8'd13,8'h00,4'd2, 0,0,2'd0,8'h00, 0,2'd0,0,2'd0,1},
    '{0,8'd0, 4'd0,0,8'd0, 8'h00,4'd0, 0,0,2'd0,8'h00, 0,2'd0,1,2'd0,0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic trig, input logic [7:0] tag, input logic [3:0] pc,
                       input logic rv, input logic [7:0] rtag, input logic [7:0] rdata,
                       input logic [3:0] ridx);
    headValid = trig; headLoadPending = trig; headLongLat = trig;
    headTag = TAG_W'(tag); headPcLow = pc;
    memRespValid = rv; memRespTag = TAG_W'(rtag);
    memRespData = DATA_W'(rdata); memRespIdx = ridx;
  endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R8 reset clearMode", 32'(clearMode), 0);
    check("R5 reset rollbackReq", 32'(rollbackReq), 0);
    check("R6 reset ckptFree", 32'(ckptFree), 0);
    @(negedge clk) rstN = 1'b1;

    // vector walk: inputs at negedge, outputs sampled 1 ns later
    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      drive(VEC[r].trig, VEC[r].tag, VEC[r].pc, VEC[r].rv, VEC[r].rtag,
            VEC[r].rdata, VEC[r].ridx);
      #1;
      check($sformatf("R1 earlyRetire row %0d", r), 32'(earlyRetire), 32'(VEC[r].eEarly));
      check($sformatf("R4 stallRetire row %0d", r), 32'(stallRetire), 32'(VEC[r].eStall));
      if (VEC[r].eEarly) begin
        check($sformatf("R1 snapTake row %0d", r), 32'(snapTake), 1);
        check($sformatf("R2 snapSlot row %0d", r), 32'(snapSlot), 32'(VEC[r].eSnap));
        check($sformatf("R3 predValue row %0d", r), predValue, 32'(VEC[r].ePred));
      end
      check($sformatf("R5 rollbackReq row %0d", r), 32'(rollbackReq), 32'(VEC[r].eRb));
      if (VEC[r].eRb)
        check($sformatf("R5 rollbackSlot row %0d", r), 32'(rollbackSlot), 32'(VEC[r].eRbs));
      check($sformatf("R6 R7 ckptFree row %0d", r), 32'(ckptFree), 32'(VEC[r].eRel));
      if (VEC[r].eRel)
        check($sformatf("R7 ckptFreeSlot row %0d", r), 32'(ckptFreeSlot), 32'(VEC[r].eRels));
      check($sformatf("R8 clearMode row %0d", r), 32'(clearMode), 32'(VEC[r].eClr));
    end
    // rows 12-13 cover R9, rows 1-2 and 23 cover R10

    // R1: each qualifier is needed
    @(negedge clk);
    drive(0, 0, 4'd3, 0, 0, 0, 0);
    headValid = 1; headLoadPending = 1; headLongLat = 0;
    #1 check("R1 no long-latency mark", 32'(earlyRetire), 0);
    headValid = 0; headLongLat = 1;
    #1 check("R1 head not valid", 32'(earlyRetire), 0);
    headValid = 1; headLoadPending = 0;
    #1 check("R1 load resolved", 32'(earlyRetire), 0);
    headLoadPending = 1;
    #1 check("R1 full trigger", 32'(earlyRetire), 1);
    check("R3 trained entry", predValue, 32'h22);
    check("R2 next slot", 32'(snapSlot), 1);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0);
    #1 check("R8 clear after trigger", 32'(clearMode), 1);

    // reset with a live checkpoint clears pool and table
    @(negedge clk) rstN = 1'b0;
    #1 check("R8 reset drops clearMode", 32'(clearMode), 0);
    @(negedge clk) rstN = 1'b1;
    drive(1, 8'd20, 4'd3, 0, 0, 0, 0);
    #1;
    check("R3 table cleared by reset", predValue, 0);
    check("R2 first slot after reset", 32'(snapSlot), 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule